// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block makes a group of participants wait for each other. Each participant pulses its arrive input when it reaches the synchronization point, then watches its pass output. The pass output drops as soon as the arrival is taken. It rises again for every active participant in the same cycle, once the number of arrivals in the episode reaches the configured group size. A shared counter tallies the arrivals. The arrival that completes the group clears the counter.

The barrier can be used again at once, with no gap between episodes. A global sense bit toggles at the end of each episode. Each participant keeps a private sense bit that toggles when its arrival is taken. A participant is waiting while the two bits differ. No flag is ever set and later cleared. A fast participant that re-enters early therefore only flips its own bit and waits for the next toggle, and a slow participant that has not yet acted on its pass stays released. Lanes whose index is at or above the group size take no part.

Top module: `sense_barrier`

## Requirements
- R1: After reset the arrival count is zero, the pass output is high for every lane whose index is below group_size_i, and it is low for every other lane.
- R2: An arrive pulse on an active lane that is not waiting is taken at the next clock edge. From then on, pass_o of that lane is low and stays low until the episode completes.
- R3: Arrivals taken in one cycle, from any number of lanes together, all add to the episode's count. The group completes only when the count reaches group_size_i.
- R4: At the edge where the count reaches group_size_i, the global sense toggles and the count returns to zero. From that edge on, pass_o is high on every active lane.
- R5: The lane whose arrival completes the group keeps pass_o high throughout; it never sees a low cycle.
- R6: An arrive pulse on a lane that is already waiting is ignored. It is not counted, and the lane stays waiting.
- R7: A lane that re-arrives after release, before the other lanes have arrived again, waits for the next episode. The lanes that have not re-arrived keep pass_o high, and the next episode completes normally.
- R8: A lane with index at or above group_size_i is inactive. Its pass_o is low and its arrive pulses are ignored. When it becomes active again, it starts out released.
- R9: When all lanes of a full group (group_size_i equal to the lane count) arrive in the same cycle, the episode completes at that edge, and no lane's pass_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N_LANES | One arrival pulse per lane, one cycle wide |
| group_size_i | input | CNT_W | Number of participating lanes (1..N_LANES); lanes 0..group_size_i-1 take part |
| pass_o | output | N_LANES | Per-lane pass indication; high means released or idle, low means waiting |

## Verification
The assertions check four things on every cycle: the count stays below the group size, a global sense toggle leaves the count empty and every active lane released, a waiting lane stays waiting until a toggle arrives, and the completing lane never drops its pass. Other behaviours show up only in the bench's scenarios. These are the exact arrival tallies for simultaneous and duplicate pulses, the back-to-back reuse pattern in which a fast lane re-enters early, and the effect of changing the group size between episodes. All of them are observed through pass_o, cycle by cycle.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  // width able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // width able to hold a running count below n plus up to n new arrivals
  function automatic int unsigned sum_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(2 * n);
  endfunction

endpackage

// File: rtl/barrier_lane.sv
module barrier_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive_i,
  input  logic active_i,
  input  logic gsense_i,
  input  logic flip_i,
  output logic accept_o,
  output logic pass_o
);

  logic lsense_q;
  logic lsense_d;
  logic waiting;

  assign waiting  = lsense_q ^ gsense_i;
  assign accept_o = arrive_i & active_i & ~waiting;
  assign pass_o   = active_i & ~waiting;

  // inactive lanes shadow the next global sense so they re-enter released
  always_comb begin
    if (active_i) lsense_d = lsense_q ^ accept_o;
    else          lsense_d = gsense_i ^ flip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsense_q <= 1'b0;
    else        lsense_q <= lsense_d;
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !pass_o && !flip_i) |=> !pass_o); // R6

  AST_LAST_KEEPS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && flip_i) |=> (pass_o || !active_i)); // R5

  AST_DROP_NEEDS_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i) && $fell(pass_o)) |-> $past(arrive_i)); // R2

endmodule

// File: rtl/barrier_tally.sv
module barrier_tally #(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned CNT_W   = barrier_pkg::cnt_width(N_LANES),
  parameter int unsigned SUM_W   = barrier_pkg::sum_width(N_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] accept_i,
  input  logic [CNT_W-1:0]   group_size_i,
  output logic               gsense_o,
  output logic               flip_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [SUM_W-1:0] taken;
  logic [SUM_W-1:0] sum;

  always_comb begin
    taken = '0;
    for (int i = 0; i < int'(N_LANES); i++) taken = taken + SUM_W'(accept_i[i]);
  end

  assign sum     = SUM_W'(count_q) + taken;
  assign flip_o  = (|accept_i) && (sum >= SUM_W'(group_size_i));
  assign count_d = flip_o ? '0 : CNT_W'(sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      gsense_o <= 1'b0;
    end else begin
      count_q  <= count_d;
      gsense_o <= gsense_o ^ flip_o;
    end
  end

  AST_COUNT_UNDER_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (group_size_i != '0 && $stable(group_size_i)) |-> (count_q < group_size_i)); // R3

  AST_TOGGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (gsense_o != $past(gsense_o)) |-> (count_q == '0)); // R4

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int unsigned N_LANES = 4,
  localparam int unsigned CNT_W  = barrier_pkg::cnt_width(N_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] arrive_i,
  input  logic [CNT_W-1:0]   group_size_i,
  output logic [N_LANES-1:0] pass_o
);

  logic [N_LANES-1:0] active;
  logic [N_LANES-1:0] accept;
  logic               gsense;
  logic               flip;

  generate
    for (genvar g = 0; g < int'(N_LANES); g++) begin : g_lane
      assign active[g] = (CNT_W'(g) < group_size_i);
      barrier_lane u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive_i[g]),
        .active_i (active[g]),
        .gsense_i (gsense),
        .flip_i   (flip),
        .accept_o (accept[g]),
        .pass_o   (pass_o[g])
      );
    end
  endgenerate

  barrier_tally #(.N_LANES(N_LANES)) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .group_size_i (group_size_i),
    .gsense_o     (gsense),
    .flip_o       (flip)
  );

  AST_ALL_PASS_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(group_size_i) && gsense != $past(gsense)) |-> (pass_o == active)); // R4

endmodule

// File: tb/sense_barrier_bench.sv
module sense_barrier_bench;
  localparam int unsigned N = 4;
  localparam int unsigned CW = barrier_pkg::cnt_width(N);

  typedef struct {
    logic [N-1:0] exp;
    string        req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  arrive = '0;
  logic [CW-1:0] gsize = CW'(N);
  logic [N-1:0]  pass;

  item_t sb[$];
  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sense_barrier #(.N_LANES(N)) u_sense_barrier (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive),
    .group_size_i(gsize), .pass_o(pass)
  );

  // driver: apply one cycle of stimulus and queue the expected pass vector
  task automatic drive(input logic [N-1:0] a, input int unsigned sz,
                       input logic [N-1:0] exp, input string req);
    item_t it;
    @(negedge clk);
    arrive = a;
    gsize  = CW'(sz);
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: after each edge, compare against the oldest queued item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        applied++;
        if (pass !== it.exp) begin
          errors++;
          $display("FAIL %s: pass_o=%b expected %b", it.req, pass, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #23;
    applied++;
    if (pass !== 4'b1111) begin
      errors++;
      $display("FAIL R1: pass_o=%b expected 1111 in reset", pass);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b0000, 4, 4'b1111, "R1 idle after reset");
    drive(4'b0001, 4, 4'b1110, "R2 lane0 waits");
    drive(4'b0000, 4, 4'b1110, "R2 lane0 still waits");
    drive(4'b0001, 4, 4'b1110, "R6 duplicate from lane0");
    drive(4'b0110, 4, 4'b1000, "R3 two together, count 3");
    drive(4'b0001, 4, 4'b1000, "R6 duplicate not counted");
    drive(4'b1000, 4, 4'b1111, "R4 R5 lane3 completes");
    // back-to-back reuse with an early re-entrant
    drive(4'b0001, 4, 4'b1110, "R7 fast lane re-enters");
    drive(4'b0000, 4, 4'b1110, "R7 slow lanes stay released");
    drive(4'b0100, 4, 4'b1010, "R7 lane2 joins");
    drive(4'b1010, 4, 4'b1111, "R7 R3 episode completes");
    drive(4'b1111, 4, 4'b1111, "R9 all at once");
    drive(4'b0000, 4, 4'b1111, "R9 stays released");
    // smaller group
    drive(4'b0000, 2, 4'b0011, "R8 size 2 lanes 2,3 low");
    drive(4'b1100, 2, 4'b0011, "R8 inactive arrivals ignored");
    drive(4'b0001, 2, 4'b0010, "R2 lane0 waits in size 2");
    drive(4'b1000, 2, 4'b0010, "R8 inactive not counted");
    drive(4'b0010, 2, 4'b0011, "R4 size 2 completes");
    drive(4'b0000, 4, 4'b1111, "R8 lanes return released");
    drive(4'b0011, 4, 4'b1100, "R3 two counted");
    drive(4'b0100, 4, 4'b1000, "R3 third counted");
    drive(4'b1000, 4, 4'b1111, "R4 R5 fourth completes");
    drive(4'b0000, 4, 4'b1111, "R4 idle after completion");
    @(negedge clk);
    arrive = '0;
    while (sb.size() > 0) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule